// File: doc/BRIEF.md
# Cluster Performance Counter Bank

This block counts activity for a multicore cluster. It holds a configurable number of 32-bit event counters, up to 31 of them, plus one 64-bit cycle counter. Software reaches all state through one flat register port. Writes take effect on the clock edge. Reads are combinational from the address. Each event counter has a programmable event type. The type picks one line of a 64-wide event pulse vector, or, for the cycle code, selects counting on every enabled clock.

Counters are reached indirectly. A select register names one counter, and two indirect registers then expose that counter's event type and its value. The cycle counter also has two direct registers, one for each 32-bit half.

Enables, interrupt enables and overflow flags are kept as 32-bit bitmaps. Bit i stands for event counter i and bit 31 stands for the cycle counter. Each bitmap is changed through write-one-to-set and write-one-to-clear registers. A level interrupt is raised while any overflow flag is pending and that flag's interrupt enable is set. A pair of read-only registers reports which common event codes exist.

Top module: `clpm_bank`

## Requirements
- R1: After synchronous reset the following are all zero and the interrupt is low: every counter, every bitmap, the select register and the global enable.
- R2: Reading the control register (address 0) returns:
  - the global enable in bit 0;
  - zero in bits 1 and 2;
  - NUM_EVT in bits 15:11;
  - ID_CODE in bits 23:16;
  - IMPL_CODE in bits 31:24;
  - zero in all other bits.
- R3: The enable bitmap (set at address 1, clear at address 2) and the interrupt-enable bitmap (set at address 6, clear at address 7) behave the same way:
  - each 1 written sets or clears only that bit, and 0 bits have no effect;
  - both addresses read the current bitmap;
  - bits of unimplemented counters (i >= NUM_EVT, i != 31) stay 0.
- R4: For the overflow bitmap, a 1 written at address 3 sets that flag. Address 4 reads the pending flags, and a 1 written there clears that flag.
- R5: The select register (address 5) keeps bits 4:0 of the write. Address 10 (event type, low 16 bits) and address 11 (value) then read and write the counter it names.
- R6: A select value of NUM_EVT or above, including 31, makes addresses 10 and 11 read 0, and writes to them change no counter.
- R7: Address 8 reads and writes cycle counter bits 31:0 and address 9 bits 63:32, independent of the select register.
- R8: On each clock edge where the global enable and the counter's enable bit are both 1, an event counter adds one if its type is 0x11 or if evt_in[type] is 1 (for type < 64). The cycle counter adds one on every such edge. Nothing counts when the global enable is 0.
- R9: Writing the control register with bit 1 set zeroes all event counters, and with bit 2 set zeroes the cycle counter. This takes precedence over counting on that edge.
- R10: When a counter steps from all ones to zero, its overflow flag (bit 31 for the cycle counter) is set on that same edge.
- R11: ovf_irq is 1 exactly while some overflow flag and its interrupt enable are both 1. It follows any register change on the same edge.
- R12: Address 12 reads bits 31:0 of the CAP_MAP common-event bitmap and address 13 reads bits 63:32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| evt_in | input | 64 | Event pulse lines, one per common event code |
| ovf_irq | output | 1 | Level overflow interrupt |

## Verification
Register writes are presented between edges and take effect on the next rising edge. Read data is combinational from the address, so each read is checked one time step after the address settles at a falling edge. A count, an overflow flag and the interrupt change on the same edge that samples the enabling state. The bench counts the exact edges between the write that enables counting and the write that disables it, and counts an event pulse only on the edge that samples it. Overflow and interrupt checks are placed one falling edge after the rising edge that is due to cause the wrap.

// File: rtl/clpm_pkg.sv
package clpm_pkg;

    localparam int DATA_W   = 32;
    localparam int CYC_W    = 64;
    localparam int SEL_W    = 5;
    localparam int ADDR_W   = 4;
    localparam int EVT_IN_W = 64;
    localparam int CYC_BIT  = 31;
    localparam logic [7:0] CODE_CYCLES = 8'h11;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL     = 4'd0,
        A_EN_SET   = 4'd1,
        A_EN_CLR   = 4'd2,
        A_OVF_SET  = 4'd3,
        A_OVF_CLR  = 4'd4,
        A_SEL      = 4'd5,
        A_IRQ_SET  = 4'd6,
        A_IRQ_CLR  = 4'd7,
        A_CYC_LO   = 4'd8,
        A_CYC_HI   = 4'd9,
        A_EVT_TYPE = 4'd10,
        A_EVT_VAL  = 4'd11,
        A_CAP_LO   = 4'd12,
        A_CAP_HI   = 4'd13
    } reg_addr_e;

    // One write strobe per writable register
    typedef struct packed {
        logic ctrl;
        logic en_set;
        logic en_clr;
        logic ovf_set;
        logic ovf_clr;
        logic sel;
        logic irq_set;
        logic irq_clr;
        logic cyc_lo;
        logic cyc_hi;
        logic evt_type;
        logic evt_val;
    } wr_strobe_t;

    // Bits that exist in every counter bitmap
    function automatic logic [DATA_W-1:0] impl_mask(input int n_evt);
        return (DATA_W'(1) << CYC_BIT) | ((DATA_W'(1) << n_evt) - DATA_W'(1));
    endfunction

    // Write-one set/clear update of a bitmap
    function automatic logic [DATA_W-1:0] set_clr(
        input logic [DATA_W-1:0] cur,
        input logic [DATA_W-1:0] set_bits,
        input logic [DATA_W-1:0] clr_bits,
        input logic [DATA_W-1:0] mask
    );
        return ((cur | set_bits) & ~clr_bits) & mask;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_word(
        input logic       en,
        input logic [4:0] n_evt,
        input logic [7:0] id_code,
        input logic [7:0] impl_code
    );
        return {impl_code, id_code, n_evt, 10'b0, en};
    endfunction

endpackage

// File: rtl/clpm_wr_decode.sv
module clpm_wr_decode
    import clpm_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output wr_strobe_t        stb
);
    reg_addr_e a;

    always_comb begin
        a   = reg_addr_e'(addr);
        stb = '0;
        if (wr_en) begin
            case (a)
                A_CTRL:     stb.ctrl     = 1'b1;
                A_EN_SET:   stb.en_set   = 1'b1;
                A_EN_CLR:   stb.en_clr   = 1'b1;
                A_OVF_SET:  stb.ovf_set  = 1'b1;
                A_OVF_CLR:  stb.ovf_clr  = 1'b1;
                A_SEL:      stb.sel      = 1'b1;
                A_IRQ_SET:  stb.irq_set  = 1'b1;
                A_IRQ_CLR:  stb.irq_clr  = 1'b1;
                A_CYC_LO:   stb.cyc_lo   = 1'b1;
                A_CYC_HI:   stb.cyc_hi   = 1'b1;
                A_EVT_TYPE: stb.evt_type = 1'b1;
                A_EVT_VAL:  stb.evt_val  = 1'b1;
                default:    stb          = '0;
            endcase
        end
    end
endmodule

// File: rtl/clpm_evt_counter.sv
module clpm_evt_counter
    import clpm_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int TYPE_W = 16,
    parameter int IN_W   = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              zero,
    input  logic              wr_type,
    input  logic              wr_val,
    input  logic [TYPE_W-1:0] type_in,
    input  logic [CNT_W-1:0]  val_in,
    input  logic [IN_W-1:0]   evt_in,
    output logic [TYPE_W-1:0] type_q,
    output logic [CNT_W-1:0]  val_q,
    output logic              wrap
);
    localparam int IDX_W = $clog2(IN_W);

    logic hit;
    logic step;

    always_comb begin
        hit = 1'b0;
        if (type_q == TYPE_W'(CODE_CYCLES))
            hit = 1'b1;
        else if (type_q < TYPE_W'(IN_W))
            hit = evt_in[type_q[IDX_W-1:0]];
    end

    assign step = run && hit && !zero && !wr_val;
    assign wrap = step && (&val_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            type_q <= '0;
            val_q  <= '0;
        end else begin
            if (wr_type)
                type_q <= type_in;
            if (zero)
                val_q <= '0;
            else if (wr_val)
                val_q <= val_in;
            else if (step)
                val_q <= val_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/clpm_cycle_counter.sv
module clpm_cycle_counter
    import clpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              zero,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [CYC_W-1:0]  val_q,
    output logic              wrap
);
    logic step;

    assign step = run && !zero && !wr_lo && !wr_hi;
    assign wrap = step && (&val_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
        end else if (zero) begin
            val_q <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) val_q[DATA_W-1:0]     <= wdata;
            if (wr_hi) val_q[CYC_W-1:DATA_W] <= wdata;
        end else if (step) begin
            val_q <= val_q + CYC_W'(1);
        end
    end
endmodule

// File: rtl/clpm_bank.sv
module clpm_bank
    import clpm_pkg::*;
#(
    parameter int          NUM_EVT   = 4,
    parameter int          TYPE_W    = 16,
    parameter logic [7:0]  ID_CODE   = 8'h5A,
    parameter logic [7:0]  IMPL_CODE = 8'hC3,
    parameter logic [63:0] CAP_MAP   = 64'h0000_F0F0_0022_0009
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [EVT_IN_W-1:0] evt_in,
    output logic                ovf_irq
);
    localparam logic [DATA_W-1:0] IMPL = impl_mask(NUM_EVT);
    localparam logic [4:0]        NEVT = 5'(NUM_EVT);

    wr_strobe_t stb;
    logic              glob_en_q;
    logic [DATA_W-1:0] cnt_en_q, irq_en_q, ovf_q;
    logic [SEL_W-1:0]  sel_q;
    logic [DATA_W-1:0] wrap_vec;
    logic [CYC_W-1:0]  cyc_val;
    logic              zero_evt, zero_cyc;
    logic [TYPE_W-1:0] evt_type [NUM_EVT];
    logic [DATA_W-1:0] evt_val  [NUM_EVT];
    logic [TYPE_W-1:0] ind_type;
    logic [DATA_W-1:0] ind_val;

    clpm_wr_decode u_dec (
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .stb   (stb)
    );

    assign zero_evt = stb.ctrl && reg_wdata[1];
    assign zero_cyc = stb.ctrl && reg_wdata[2];

    // Event counters occupy bitmap bits 0..NUM_EVT-1
    for (genvar i = 0; i < CYC_BIT; i++) begin : g_slot
        if (i < NUM_EVT) begin : g_cnt
            clpm_evt_counter #(
                .CNT_W  (DATA_W),
                .TYPE_W (TYPE_W),
                .IN_W   (EVT_IN_W)
            ) u_cnt (
                .clk     (clk),
                .rst     (rst),
                .run     (glob_en_q && cnt_en_q[i]),
                .zero    (zero_evt),
                .wr_type (stb.evt_type && (sel_q == SEL_W'(i))),
                .wr_val  (stb.evt_val && (sel_q == SEL_W'(i))),
                .type_in (reg_wdata[TYPE_W-1:0]),
                .val_in  (reg_wdata),
                .evt_in  (evt_in),
                .type_q  (evt_type[i]),
                .val_q   (evt_val[i]),
                .wrap    (wrap_vec[i])
            );
        end else begin : g_none
            assign wrap_vec[i] = 1'b0;
        end
    end

    clpm_cycle_counter u_cyc (
        .clk   (clk),
        .rst   (rst),
        .run   (glob_en_q && cnt_en_q[CYC_BIT]),
        .zero  (zero_cyc),
        .wr_lo (stb.cyc_lo),
        .wr_hi (stb.cyc_hi),
        .wdata (reg_wdata),
        .val_q (cyc_val),
        .wrap  (wrap_vec[CYC_BIT])
    );

    // Control state and bitmaps; a hardware wrap beats a clear on the same edge
    always_ff @(posedge clk) begin
        if (rst) begin
            glob_en_q <= 1'b0;
            cnt_en_q  <= '0;
            irq_en_q  <= '0;
            ovf_q     <= '0;
            sel_q     <= '0;
        end else begin
            if (stb.ctrl)
                glob_en_q <= reg_wdata[0];
            cnt_en_q <= set_clr(cnt_en_q,
                                stb.en_set ? reg_wdata : '0,
                                stb.en_clr ? reg_wdata : '0, IMPL);
            irq_en_q <= set_clr(irq_en_q,
                                stb.irq_set ? reg_wdata : '0,
                                stb.irq_clr ? reg_wdata : '0, IMPL);
            ovf_q    <= set_clr(ovf_q,
                                stb.ovf_set ? reg_wdata : '0,
                                stb.ovf_clr ? reg_wdata : '0, IMPL) | wrap_vec;
            if (stb.sel)
                sel_q <= reg_wdata[SEL_W-1:0];
        end
    end

    // Indirect view of the selected counter; unimplemented index reads zero
    always_comb begin
        ind_type = '0;
        ind_val  = '0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (sel_q == SEL_W'(i)) begin
                ind_type = evt_type[i];
                ind_val  = evt_val[i];
            end
        end
    end

    always_comb begin
        case (reg_addr_e'(reg_addr))
            A_CTRL:                reg_rdata = ctrl_word(glob_en_q, NEVT, ID_CODE, IMPL_CODE);
            A_EN_SET, A_EN_CLR:    reg_rdata = cnt_en_q;
            A_OVF_SET, A_OVF_CLR:  reg_rdata = ovf_q;
            A_SEL:                 reg_rdata = DATA_W'(sel_q);
            A_IRQ_SET, A_IRQ_CLR:  reg_rdata = irq_en_q;
            A_CYC_LO:              reg_rdata = cyc_val[DATA_W-1:0];
            A_CYC_HI:              reg_rdata = cyc_val[CYC_W-1:DATA_W];
            A_EVT_TYPE:            reg_rdata = DATA_W'(ind_type);
            A_EVT_VAL:             reg_rdata = ind_val;
            A_CAP_LO:              reg_rdata = CAP_MAP[31:0];
            A_CAP_HI:              reg_rdata = CAP_MAP[63:32];
            default:               reg_rdata = '0;
        endcase
    end

    assign ovf_irq = |(ovf_q & irq_en_q);

endmodule

// File: rtl/clpm_bank_chk.sv
module clpm_bank_chk
    import clpm_pkg::*;
#(
    parameter int NUM_EVT = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              irq,
    input logic [DATA_W-1:0] cnten,
    input logic [DATA_W-1:0] ovf,
    input logic [CYC_W-1:0]  ccnt,
    input logic              glob_en
);
    localparam logic [DATA_W-1:0] IMPL = impl_mask(NUM_EVT);

    AST_CTRL_LAYOUT: assert property (@(posedge clk) disable iff (rst)
        (addr == A_CTRL) |-> (rdata[2:1] == 2'b00 && rdata[15:11] == 5'(NUM_EVT))); // R2

    AST_EN_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_EN_SET) |=> ((cnten & $past(wdata & IMPL)) == $past(wdata & IMPL))); // R3

    AST_EN_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_EN_CLR) |=> ((cnten & $past(wdata)) == '0)); // R3

    AST_NO_COUNT_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!glob_en && !(wr_en && (addr == A_CYC_LO || addr == A_CYC_HI || addr == A_CTRL)))
        |=> $stable(ccnt)); // R8

    AST_CYC_ZEROED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_CTRL && wdata[2]) |=> (ccnt == '0)); // R9

    AST_CYC_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
        (ccnt == '0 && $past(ccnt) == '1 && !$past(wr_en)) |-> ovf[CYC_BIT]); // R10

    AST_IRQ_OFF_AFTER_MASK: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_IRQ_CLR && wdata == '1) |=> !irq); // R11

endmodule

bind clpm_bank clpm_bank_chk #(.NUM_EVT(NUM_EVT)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .irq     (ovf_irq),
    .cnten   (cnt_en_q),
    .ovf     (ovf_q),
    .ccnt    (cyc_val),
    .glob_en (glob_en_q)
);

// File: tb/clpm_bank_test.sv
module clpm_bank_test;
    import clpm_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] evt_in = '0;
    logic        ovf_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    clpm_bank uut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_in    (evt_in),
        .ovf_irq   (ovf_irq)
    );

    typedef struct packed {
        logic        wr;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } step_t;

    localparam int NSTEP = 55;
    localparam step_t STEPS [NSTEP] = '{
        '{1'b0, A_CTRL,     32'hC35A2000, 4'd2},  // R2 reset layout
        '{1'b0, A_EN_SET,   32'h00000000, 4'd1},  // R1
        '{1'b0, A_OVF_CLR,  32'h00000000, 4'd1},  // R1
        '{1'b0, A_IRQ_SET,  32'h00000000, 4'd1},  // R1
        '{1'b0, A_SEL,      32'h00000000, 4'd1},  // R1
        '{1'b0, A_CYC_LO,   32'h00000000, 4'd1},  // R1
        '{1'b0, A_CYC_HI,   32'h00000000, 4'd1},  // R1
        '{1'b0, A_CAP_LO,   32'h00220009, 4'd12}, // R12
        '{1'b0, A_CAP_HI,   32'h0000F0F0, 4'd12}, // R12
        '{1'b1, A_EN_SET,   32'hFFFFFFFF, 4'd3},  // R3
        '{1'b0, A_EN_SET,   32'h8000000F, 4'd3},  // R3 only implemented bits
        '{1'b1, A_EN_CLR,   32'h00000005, 4'd3},
        '{1'b0, A_EN_CLR,   32'h8000000A, 4'd3},
        '{1'b1, A_EN_CLR,   32'h00000000, 4'd3},  // R3 zeros no effect
        '{1'b0, A_EN_SET,   32'h8000000A, 4'd3},
        '{1'b1, A_EN_CLR,   32'hFFFFFFFF, 4'd3},
        '{1'b0, A_EN_SET,   32'h00000000, 4'd3},
        '{1'b1, A_IRQ_SET,  32'h80000012, 4'd3},
        '{1'b0, A_IRQ_CLR,  32'h80000002, 4'd3},
        '{1'b1, A_IRQ_CLR,  32'h80000002, 4'd3},
        '{1'b0, A_IRQ_SET,  32'h00000000, 4'd3},
        '{1'b1, A_OVF_SET,  32'h00000003, 4'd4},  // R4
        '{1'b0, A_OVF_CLR,  32'h00000003, 4'd4},
        '{1'b1, A_OVF_CLR,  32'h00000001, 4'd4},
        '{1'b0, A_OVF_SET,  32'h00000002, 4'd4},
        '{1'b1, A_OVF_CLR,  32'h00000002, 4'd4},
        '{1'b0, A_OVF_CLR,  32'h00000000, 4'd4},
        '{1'b1, A_SEL,      32'h00000002, 4'd5},  // R5
        '{1'b0, A_SEL,      32'h00000002, 4'd5},
        '{1'b1, A_EVT_TYPE, 32'h0000002B, 4'd5},
        '{1'b0, A_EVT_TYPE, 32'h0000002B, 4'd5},
        '{1'b1, A_EVT_VAL,  32'h12345678, 4'd5},
        '{1'b0, A_EVT_VAL,  32'h12345678, 4'd5},
        '{1'b1, A_SEL,      32'h00000001, 4'd5},
        '{1'b0, A_EVT_VAL,  32'h00000000, 4'd5},
        '{1'b0, A_EVT_TYPE, 32'h00000000, 4'd5},
        '{1'b1, A_SEL,      32'h00000002, 4'd5},
        '{1'b0, A_EVT_VAL,  32'h12345678, 4'd5},
        '{1'b1, A_SEL,      32'h0000003F, 4'd5},
        '{1'b0, A_SEL,      32'h0000001F, 4'd5},  // R5 five bits kept
        '{1'b0, A_EVT_VAL,  32'h00000000, 4'd6},  // R6 index 31 reads 0
        '{1'b1, A_EVT_VAL,  32'hAAAA5555, 4'd6},  // R6 write ignored
        '{1'b1, A_SEL,      32'h00000002, 4'd6},
        '{1'b0, A_EVT_VAL,  32'h12345678, 4'd6},
        '{1'b1, A_CYC_LO,   32'hDEADBEEF, 4'd7},  // R7
        '{1'b1, A_CYC_HI,   32'h0000CAFE, 4'd7},
        '{1'b0, A_CYC_LO,   32'hDEADBEEF, 4'd7},
        '{1'b0, A_CYC_HI,   32'h0000CAFE, 4'd7},
        '{1'b1, A_CTRL,     32'h00000004, 4'd9},  // R9 cycle reset
        '{1'b0, A_CYC_LO,   32'h00000000, 4'd9},
        '{1'b0, A_CYC_HI,   32'h00000000, 4'd9},
        '{1'b0, A_EVT_VAL,  32'h12345678, 4'd9},  // R9 event counters untouched
        '{1'b1, A_CTRL,     32'h00000002, 4'd9},  // R9 event reset
        '{1'b0, A_EVT_VAL,  32'h00000000, 4'd9},
        '{1'b0, A_CTRL,     32'hC35A2000, 4'd2}   // R2 bits 1,2 read 0
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic irq_chk(input logic exp, input string tag);
        #1;
        chk(tag, {31'b0, ovf_irq}, {31'b0, exp});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    localparam logic [4:0] PAT = 5'b01101; // pulses on evt_in[3], LSB first

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        irq_chk(1'b0, "R1 irq after reset");

        for (int k = 0; k < NSTEP; k++) begin
            if (STEPS[k].wr)
                wr(STEPS[k].addr, STEPS[k].data);
            else
                rd(STEPS[k].addr, STEPS[k].data,
                   $sformatf("R%0d step %0d", STEPS[k].req, k));
        end

        // R8: counting window of 7 enabled edges, 3 event pulses
        wr(A_SEL, 0);      wr(A_EVT_TYPE, 32'h03);
        wr(A_SEL, 1);      wr(A_EVT_TYPE, 32'h11);
        wr(A_SEL, 2);      wr(A_EVT_TYPE, 32'h05);
        wr(A_EN_SET, 32'h80000007);
        wr(A_CTRL, 32'h7);
        for (int j = 0; j < 5; j++) begin
            evt_in    = '0;
            evt_in[3] = PAT[j];
            evt_in[4] = 1'b1;
            @(negedge clk);
        end
        evt_in = '0;
        wr(A_CTRL, 32'h0);
        wr(A_SEL, 0); rd(A_EVT_VAL, 32'd3, "R8 event count on line 3");
        wr(A_SEL, 1); rd(A_EVT_VAL, 32'd7, "R8 cycle-code counter");
        wr(A_SEL, 2); rd(A_EVT_VAL, 32'd0, "R8 unpulsed line stays 0");
        rd(A_CYC_LO, 32'd7, "R8 cycle counter low");
        rd(A_CYC_HI, 32'd0, "R8 cycle counter high");
        repeat (5) @(negedge clk);
        rd(A_CYC_LO, 32'd7, "R8 no count while disabled");

        // R10 and R11: event counter wrap with interrupt enabled
        wr(A_EN_CLR, 32'hFFFFFFFF);
        wr(A_SEL, 1);
        wr(A_EVT_VAL, 32'hFFFFFFFE);
        wr(A_IRQ_SET, 32'h2);
        wr(A_EN_SET, 32'h2);
        wr(A_CTRL, 32'h1);
        irq_chk(1'b0, "R11 irq low before wrap");
        @(negedge clk);
        irq_chk(1'b0, "R11 irq low at all ones");
        rd(A_EVT_VAL, 32'hFFFFFFFF, "R8 step to all ones");
        @(negedge clk);
        irq_chk(1'b1, "R10 irq on wrap edge");
        rd(A_OVF_CLR, 32'h2, "R10 overflow bit of counter 1");
        wr(A_CTRL, 32'h0);
        rd(A_EVT_VAL, 32'd2, "R10 count continues past wrap");
        wr(A_OVF_CLR, 32'h2);
        irq_chk(1'b0, "R11 irq drops after clear");

        // R10 and R11: cycle counter wrap, interrupt masked then unmasked
        wr(A_EN_CLR, 32'hFFFFFFFF);
        wr(A_IRQ_CLR, 32'hFFFFFFFF);
        wr(A_CYC_LO, 32'hFFFFFFFF);
        wr(A_CYC_HI, 32'hFFFFFFFF);
        wr(A_EN_SET, 32'h80000000);
        wr(A_CTRL, 32'h1);
        rd(A_CYC_LO, 32'hFFFFFFFF, "R7 cycle counter before wrap");
        @(negedge clk);
        rd(A_CYC_HI, 32'h0, "R10 cycle counter wrapped");
        rd(A_OVF_CLR, 32'h80000000, "R10 cycle overflow bit 31");
        irq_chk(1'b0, "R11 masked overflow");
        wr(A_CTRL, 32'h0);
        rd(A_CYC_LO, 32'd2, "R8 cycle counter after wrap");
        wr(A_IRQ_SET, 32'h80000000);
        irq_chk(1'b1, "R11 irq on unmask");
        wr(A_OVF_CLR, 32'h80000000);
        irq_chk(1'b0, "R11 irq after cycle flag clear");

        // R1: reset in the middle of activity
        wr(A_EN_SET, 32'hF);
        wr(A_OVF_SET, 32'h1);
        wr(A_IRQ_SET, 32'h1);
        irq_chk(1'b1, "R11 irq from set flag");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        irq_chk(1'b0, "R1 irq cleared by reset");
        rd(A_EN_SET,  32'h0, "R1 enables cleared");
        rd(A_OVF_CLR, 32'h0, "R1 overflow cleared");
        rd(A_IRQ_SET, 32'h0, "R1 interrupt enables cleared");
        rd(A_SEL,     32'h0, "R1 select cleared");
        rd(A_EVT_VAL, 32'h0, "R1 counter 0 cleared");

        finish_run();
    end
endmodule